// File: doc/BRIEF.md
# Segmented Speculative Adder with Selectable Correction

This block adds two unsigned N-bit operands by splitting them into equal, non-overlapping slices of L bits and adding every slice at the same time. No carry chain runs past one slice. The carry into each upper slice is guessed from the top bit pair of the slice below it: the guess is the AND of those two bits, the generate term. The XOR of the same two bits, the propagate term, is reported as a risk flag. A risk flag means the real carry could differ from the guess.

A correction-level input chooses how many slice boundaries, counted from the least significant one upward, take the real carry-out of the slice below in place of the guess. Level 0 gives the fastest and least accurate result. The highest level, one less than the number of slices, gives the exact sum. Operands and level are captured on one clock edge, and the sum, carry-out and per-boundary risk flags are presented as registered outputs one cycle later.

Top module: `ssa_adder`

## Requirements
- R1: While `rst_n` is low, `sum_o`, `carry_o` and `risk_o` are all zero.
- R2: The outputs present the result for the operands and level sampled at the previous rising clock edge, one cycle of latency.
- R3: Boundary j sits at bit k = (j+1)·L. `risk_o[j]` equals `op_a[k-1] XOR op_b[k-1]` at every correction level.
- R4: An uncorrected boundary (j ≥ `fix_level`) feeds the upper slice with the carry-in `op_a[k-1] AND op_b[k-1]`.
- R5: A corrected boundary (j < `fix_level`) feeds the upper slice with the true carry-out of the lower slice, taking into account that slice's own carry-in.
- R6: With `fix_level` = N/L−1, `{carry_o, sum_o}` equals the exact (N+1)-bit sum `op_a + op_b`.
- R7: At level 0, every slice's sum field equals its operand fields plus the guessed carry, truncated to L bits, so a carry never travels past a boundary.
- R8: `carry_o` is the carry-out of the most significant slice, computed with the carry-in that slice received (guessed or corrected).
- R9: The lowest slice always has carry-in zero, so `sum_o[L-1:0]` is always the exact low L bits of the sum.
- R10: When no boundary raises its risk flag, the result is exact at every correction level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| fix_level | input | LVLW | Number of low boundaries that use the true carry (0 to N/L−1) |
| sum_o | output | N | Registered sum |
| carry_o | output | 1 | Registered carry-out of the top slice |
| risk_o | output | N/L−1 | Registered per-boundary risk flags, bit j for boundary j |

## Verification
Every output is a register loaded once per cycle, so any wrong carry selection shows up in `sum_o` in the cycle right after the operands are applied. A boundary that picks the wrong carry source damages the upper slice's field by exactly one unit. In the long-carry case (all ones plus one), each wrong choice also shifts the boundary at which the visible carry stops, so every correction level produces a different, predictable pattern. A flag tied to the wrong bit pair shows in `risk_o` in that same cycle. Comparing the bench against both the speculation model and plain addition at every level shows each of these faults within one cycle of the stimulus that exposes it.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
    // Where a boundary takes the carry for its upper slice from.
    typedef enum logic [0:0] {
        SRC_GUESS = 1'b0,   // generate term of the lower slice's top bit pair
        SRC_TRUE  = 1'b1    // real carry-out of the lower slice
    } cin_src_e;
endpackage

// File: rtl/ssa_segment.sv
module ssa_segment #(
    parameter int W = 4
) (
    input  logic [W-1:0] seg_a,
    input  logic [W-1:0] seg_b,
    input  logic         seg_cin,
    output logic [W-1:0] seg_sum,
    output logic         seg_cout
);
    logic [W:0] wide;

    always_comb begin
        wide     = {1'b0, seg_a} + {1'b0, seg_b} + {{W{1'b0}}, seg_cin};
        seg_sum  = wide[W-1:0];
        seg_cout = wide[W];
    end
endmodule

// File: rtl/ssa_boundary.sv
module ssa_boundary
    import ssa_pkg::*;
#(
    parameter int LVLW = 2,
    parameter int IDX  = 0
) (
    input  logic            top_a,     // lower slice, top bit of op_a
    input  logic            top_b,     // lower slice, top bit of op_b
    input  logic            low_cout,  // true carry-out of lower slice
    input  logic [LVLW-1:0] level,
    output logic            cin_up,
    output logic            risk
);
    logic     guess;
    cin_src_e src;

    always_comb begin
        guess = top_a & top_b;
        risk  = top_a ^ top_b;
        // Only a propagating pair can make the guess wrong; fix it when this
        // boundary lies below the requested correction level.
        if (risk && (int'(level) > IDX)) src = SRC_TRUE;
        else                             src = SRC_GUESS;
        unique case (src)
            SRC_TRUE:  cin_up = low_cout;
            SRC_GUESS: cin_up = guess;
            default:   cin_up = guess;
        endcase
    end
endmodule

// File: rtl/ssa_adder.sv
module ssa_adder #(
    parameter int N = 16,
    parameter int L = 4,
    localparam int SEGS = N / L,
    localparam int NB   = (SEGS > 1) ? SEGS - 1 : 1,
    localparam int LVLW = (SEGS > 1) ? $clog2(SEGS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    op_a,
    input  logic [N-1:0]    op_b,
    input  logic [LVLW-1:0] fix_level,
    output logic [N-1:0]    sum_o,
    output logic            carry_o,
    output logic [NB-1:0]   risk_o
);
    logic [N-1:0]  sum_w;
    logic          carry_w;
    logic [NB-1:0] risk_w;

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        logic cin;
        logic cout;
        if (s == 0) begin : g_first
            assign cin = 1'b0;                       // R9
        end else begin : g_rest
            ssa_boundary #(.LVLW(LVLW), .IDX(s - 1)) u_bnd (
                .top_a   (op_a[s*L-1]),
                .top_b   (op_b[s*L-1]),
                .low_cout(g_seg[s-1].cout),
                .level   (fix_level),
                .cin_up  (cin),
                .risk    (risk_w[s-1])
            );
        end
        ssa_segment #(.W(L)) u_seg (
            .seg_a   (op_a[s*L +: L]),
            .seg_b   (op_b[s*L +: L]),
            .seg_cin (cin),
            .seg_sum (sum_w[s*L +: L]),
            .seg_cout(cout)
        );
    end

    if (SEGS == 1) begin : g_noflag
        assign risk_w = '0;
    end

    assign carry_w = g_seg[SEGS-1].cout;             // R8

    logic out_live_q;   // set once outputs carry a sampled result

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_o      <= '0;
            carry_o    <= 1'b0;
            risk_o     <= '0;
            out_live_q <= 1'b0;
        end else begin
            sum_o      <= sum_w;
            carry_o    <= carry_w;
            risk_o     <= risk_w;
            out_live_q <= 1'b1;
        end
    end

    assert_full_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_live_q && ($past(fix_level) == LVLW'(SEGS - 1)))
        |-> ({carry_o, sum_o} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

    assert_no_risk_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_live_q && (risk_o == '0))
        |-> ({carry_o, sum_o} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

    assert_low_slice_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_live_q |-> (sum_o[L-1:0] == L'($past(op_a[L-1:0]) + $past(op_b[L-1:0]))));

    for (genvar j = 0; j < SEGS - 1; j++) begin : g_flagchk
        assert_flag_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_live_q |-> (risk_o[j] == ($past(op_a[(j+1)*L-1]) ^ $past(op_b[(j+1)*L-1]))));
    end
endmodule

// File: tb/ssa_adder_test.sv
`timescale 1ns/1ps
module ssa_adder_test;
    localparam int N    = 16;
    localparam int L    = 4;
    localparam int SEGS = N / L;
    localparam int NB   = SEGS - 1;
    localparam int LVLW = $clog2(SEGS);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    op_a = '0;
    logic [N-1:0]    op_b = '0;
    logic [LVLW-1:0] fix_level = '0;
    logic [N-1:0]    sum_o;
    logic            carry_o;
    logic [NB-1:0]   risk_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ssa_adder #(.N(N), .L(L)) uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .fix_level(fix_level), .sum_o(sum_o), .carry_o(carry_o), .risk_o(risk_o)
    );

    // Behavioural speculation model: slice-wise integer sums.
    function automatic int model(input int a, input int b, input int lvl);
        int c = 0;
        int r = 0;
        int mask = (1 << L) - 1;
        int t = 0;
        for (int s = 0; s < SEGS; s++) begin
            t = ((a >> (s*L)) & mask) + ((b >> (s*L)) & mask) + c;
            r = r | ((t & mask) << (s*L));
            if (s < lvl) c = t >> L;
            else         c = ((a >> ((s+1)*L - 1)) & (b >> ((s+1)*L - 1))) & 1;
        end
        return r | ((t >> L) << N);
    endfunction

    function automatic int flags(input int a, input int b);
        int f = 0;
        for (int j = 0; j < NB; j++)
            f = f | ((((a ^ b) >> ((j+1)*L - 1)) & 1) << j);
        return f;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive on the falling edge; the result is registered at the next rising edge.
    task automatic apply(input int a, input int b, input int lvl);
        @(negedge clk);
        op_a = N'(a); op_b = N'(b); fix_level = LVLW'(lvl);
        @(posedge clk);
        #2;
    endtask

    function automatic int got_all();
        return int'({carry_o, sum_o});
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        op_a = 16'hFFFF; op_b = 16'hFFFF; fix_level = 2'd3;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset sum/carry", got_all(), 0);
        check("R1 reset flags", int'(risk_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R4/R5: single carry out of slice 0 through a propagating pair
        apply(16'h000F, 16'h0001, 0);
        check("R4 guessed carry lost", got_all(), 17'h00000);
        check("R3 flag boundary0", int'(risk_o), 3'b001);
        apply(16'h000F, 16'h0001, 1);
        check("R5 corrected boundary0", got_all(), 17'h00010);

        // Long chain: each level fixes one more boundary
        apply(16'hFFFF, 16'h0001, 0);
        check("R7 level0 chain", got_all(), 17'h0FFF0);
        check("R3 all flags", int'(risk_o), 3'b111);
        apply(16'hFFFF, 16'h0001, 1);
        check("R5 level1 chain", got_all(), 17'h0FF00);
        apply(16'hFFFF, 16'h0001, 2);
        check("R5 level2 chain", got_all(), 17'h0F000);
        apply(16'hFFFF, 16'h0001, 3);
        check("R6 full chain exact", got_all(), 17'h10000);

        // Generate pairs: guess correct, no flags
        apply(16'h0088, 16'h0088, 0);
        check("R10 generate guess exact", got_all(), 17'h00110);
        check("R3 no flags", int'(risk_o), 0);

        // Top slice carry-out
        apply(16'h8000, 16'h8000, 0);
        check("R8 top carry", got_all(), 17'h10000);

        // R2: back-to-back changes, each result one cycle after its inputs
        apply(16'h1234, 16'h0101, 0);
        check("R2 latency first", got_all(), 17'h01335);
        apply(16'h0F0F, 16'h0101, 3);
        check("R2 latency second", got_all(), 17'h01010);

        for (int i = 0; i < 400; i++) begin
            int a   = $urandom_range(0, 16'hFFFF);
            int b   = $urandom_range(0, 16'hFFFF);
            int lvl = i % SEGS;
            apply(a, b, lvl);
            check("R7 R4 R5 model", got_all(), model(a, b, lvl));
            check("R3 flags", int'(risk_o), flags(a, b));
            check("R9 low slice", int'(sum_o[L-1:0]), (a + b) & ((1 << L) - 1));
            if (lvl == SEGS - 1) check("R6 exact", got_all(), a + b);
            if (flags(a, b) == 0) check("R10 exact", got_all(), a + b);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule